// File: doc/BRIEF.md
# Latched Fault Status Register

This block is the global diagnostic word of a multi-channel half-bridge driver. It samples fault indications from the supply comparators, the thermal sensor, the serial protocol checker and the per-channel load detectors on one clock. It presents them as a single 8-bit status word for a serial host. Most bits latch on a fault of one cycle or more and clear when the host reads the word. The load-error bit mirrors the OR of the per-channel open-load and overcurrent flags. The power-on flag reads 0 after a reset and becomes 1 after the first read.

Supply undervoltage, supply overvoltage and thermal shutdown drive a global output-disable. It stays asserted until a read clears the latched cause. Each channel's output enable is also dropped locally while that channel reports overcurrent, and the other channels keep running. A read is a one-cycle strobe. The host takes the status word in the cycle where the strobe is high, and the clear takes effect at the following clock edge.

Top module: `drv_fault_status`

## Requirements
- R1: After reset the status word reads 0x00 and the global disable is low. Reset asserts asynchronously and is released synchronously.
- R2: The bit positions are fixed, counting from bit 7 down to bit 0: 7 protocol error, 6 load error, 5 undervoltage, 4 overvoltage, 3 power-on flag, 2 thermal shutdown, 1 thermal pre-warning, 0 reserved. A fault input high for one clock sets its bit at that clock edge.
- R3: A latched fault bit (7, 5, 4, 2, 1) holds without a read. A read strobe clears it at the next edge if its fault input is low in the read cycle.
- R4: A fault input that is high in the read cycle leaves its bit set after the read.
- R5: The load-error bit (6) equals, one clock later, the OR of all channel open-load and overcurrent flags. It falls by itself when they are all low, and a read does not affect it.
- R6: The power-on flag (3) reads 0 after every reset. It reads 1 from the edge after the first read strobe onward, until the next reset.
- R7: The reserved bit (0) always reads 0.
- R8: The global disable is high while bit 5, bit 4 or bit 2 is set. Protocol error and pre-warning do not cause it.
- R9: A channel's enable output equals its request, forced low while that channel's overcurrent flag is high or the global disable is high. Other channels are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset (power-on of enable or logic supply) |
| rd_i | input | 1 | Host read strobe, one cycle |
| proto_err_i | input | 1 | Serial protocol error event |
| uv_i | input | 1 | Supply undervoltage indication |
| ov_i | input | 1 | Supply overvoltage indication |
| tsd_i | input | 1 | Thermal shutdown indication |
| tpw_i | input | 1 | Thermal pre-warning indication |
| ch_ol_i | input | N_CH | Per-channel open-load flags |
| ch_oc_i | input | N_CH | Per-channel overcurrent flags |
| ch_req_i | input | N_CH | Per-channel output enable request |
| status_o | output | 8 | Global status word |
| gdis_o | output | 1 | Global output disable |
| ch_en_o | output | N_CH | Per-channel gated output enable |

## Verification
A wrong latch state shows up at status_o one edge after the fault or read that exposed it. Examples are a bit that fails to stick, clears while its fault persists, or survives a read. Because gdis_o and ch_en_o derive from the same latched bits, a stuck shutdown cause is visible at the same time on those outputs. A broken load-error mirror or power-on flag is seen on the first read sequence after reset, within two cycles. The stimulus walks faults that arrive before, during and after read strobes to reach these states.

// File: rtl/drv_fault_pkg.sv
package drv_fault_pkg;
  localparam int BIT_PERR = 7;
  localparam int BIT_LE   = 6;
  localparam int BIT_UV   = 5;
  localparam int BIT_OV   = 4;
  localparam int BIT_NPOR = 3;
  localparam int BIT_TSD  = 2;
  localparam int BIT_TPW  = 1;
  localparam int BIT_RSVD = 0;
  localparam int STAT_W   = 8;

  typedef struct packed {
    logic perr;
    logic uv;
    logic ov;
    logic tsd;
    logic tpw;
  } cor_flags_t;

  localparam int N_COR = $bits(cor_flags_t);
endpackage

// File: rtl/drv_rst_sync.sv
module drv_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/drv_cor_latch.sv
module drv_cor_latch #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic         rd_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_r;
  logic [W-1:0] q_d;
  logic         q_en;

  // a set in the read cycle wins over the clear
  always_comb begin
    q_en = rd_i | (|set_i);
    q_d  = (q_r & {W{~rd_i}}) | set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_r <= '0;
    else if (q_en) q_r <= q_d;
  end

  assign q_o = q_r;
endmodule

// File: rtl/drv_chan_gate.sv
module drv_chan_gate #(
  parameter int N_CH = 6
) (
  input  logic [N_CH-1:0] req_i,
  input  logic [N_CH-1:0] oc_i,
  input  logic            gdis_i,
  output logic [N_CH-1:0] en_o
);
  for (genvar k = 0; k < N_CH; k++) begin : g_ch
    assign en_o[k] = req_i[k] & ~oc_i[k] & ~gdis_i;
  end
endmodule

// File: rtl/drv_fault_status.sv
module drv_fault_status
  import drv_fault_pkg::*;
#(
  parameter int N_CH        = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_i,
  input  logic              proto_err_i,
  input  logic              uv_i,
  input  logic              ov_i,
  input  logic              tsd_i,
  input  logic              tpw_i,
  input  logic [N_CH-1:0]   ch_ol_i,
  input  logic [N_CH-1:0]   ch_oc_i,
  input  logic [N_CH-1:0]   ch_req_i,
  output logic [STAT_W-1:0] status_o,
  output logic              gdis_o,
  output logic [N_CH-1:0]   ch_en_o
);
  logic       rst_int_n;
  cor_flags_t set_v;
  cor_flags_t lat_v;
  logic       le_q, le_d, le_en;
  logic       npor_q, npor_en;

  drv_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  always_comb begin
    set_v.perr = proto_err_i;
    set_v.uv   = uv_i;
    set_v.ov   = ov_i;
    set_v.tsd  = tsd_i;
    set_v.tpw  = tpw_i;
  end

  drv_cor_latch #(.W(N_COR)) u_cor (
    .clk   (clk),
    .rst_n (rst_int_n),
    .set_i (set_v),
    .rd_i  (rd_i),
    .q_o   (lat_v)
  );

  // load-error summary and power-on flag: next state
  always_comb begin
    le_d    = |(ch_ol_i | ch_oc_i);
    le_en   = le_d ^ le_q;
    npor_en = rd_i & ~npor_q;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      le_q   <= 1'b0;
      npor_q <= 1'b0;
    end else begin
      if (le_en)   le_q   <= le_d;
      if (npor_en) npor_q <= 1'b1;
    end
  end

  always_comb begin
    status_o           = '0;
    status_o[BIT_PERR] = lat_v.perr;
    status_o[BIT_LE]   = le_q;
    status_o[BIT_UV]   = lat_v.uv;
    status_o[BIT_OV]   = lat_v.ov;
    status_o[BIT_NPOR] = npor_q;
    status_o[BIT_TSD]  = lat_v.tsd;
    status_o[BIT_TPW]  = lat_v.tpw;
    status_o[BIT_RSVD] = 1'b0;
    gdis_o             = lat_v.uv | lat_v.ov | lat_v.tsd;
  end

  drv_chan_gate #(.N_CH(N_CH)) u_gate (
    .req_i  (ch_req_i),
    .oc_i   (ch_oc_i),
    .gdis_i (gdis_o),
    .en_o   (ch_en_o)
  );
endmodule

// File: rtl/drv_fault_status_chk.sv
module drv_fault_status_chk
  import drv_fault_pkg::*;
#(
  parameter int N_CH = 6
) (
  input logic              clk,
  input logic              rst_ok,
  input logic              rd_i,
  input logic              proto_err_i,
  input logic              uv_i,
  input logic              tsd_i,
  input logic              tpw_i,
  input logic [N_CH-1:0]   ch_ol_i,
  input logic [N_CH-1:0]   ch_oc_i,
  input logic [STAT_W-1:0] status_o,
  input logic              gdis_o,
  input logic [N_CH-1:0]   ch_en_o
);
  // R2
  uv_set_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    uv_i |=> status_o[BIT_UV]);
  // R2
  perr_set_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    proto_err_i |=> status_o[BIT_PERR]);
  // R3
  tpw_hold_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (status_o[BIT_TPW] && !rd_i) |=> status_o[BIT_TPW]);
  // R3
  tpw_clear_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (rd_i && !tpw_i) |=> !status_o[BIT_TPW]);
  // R4
  tsd_persist_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (rd_i && tsd_i) |=> status_o[BIT_TSD]);
  // R5
  le_set_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (|(ch_ol_i | ch_oc_i)) |=> status_o[BIT_LE]);
  // R5
  le_clr_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    !(|(ch_ol_i | ch_oc_i)) |=> !status_o[BIT_LE]);
  // R6
  npor_set_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    rd_i |=> status_o[BIT_NPOR]);
  // R6
  npor_hold_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    status_o[BIT_NPOR] |=> status_o[BIT_NPOR]);
  // R7
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    !status_o[BIT_RSVD]);
  // R8
  gdis_set_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    uv_i |=> gdis_o);
  // R8
  gdis_cause_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    !(status_o[BIT_UV] || status_o[BIT_OV] || status_o[BIT_TSD]) |-> !gdis_o);
  // R9
  oc_off_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    !(|(ch_oc_i & ch_en_o)));
  // R9
  gdis_off_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    gdis_o |-> (ch_en_o == '0));
endmodule

bind drv_fault_status drv_fault_status_chk #(.N_CH(N_CH)) u_chk (
  .clk         (clk),
  .rst_ok      (rst_int_n),
  .rd_i        (rd_i),
  .proto_err_i (proto_err_i),
  .uv_i        (uv_i),
  .tsd_i       (tsd_i),
  .tpw_i       (tpw_i),
  .ch_ol_i     (ch_ol_i),
  .ch_oc_i     (ch_oc_i),
  .status_o    (status_o),
  .gdis_o      (gdis_o),
  .ch_en_o     (ch_en_o)
);

// File: tb/drv_fault_status_tb.sv
module drv_fault_status_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N_CH = 6;
  localparam int NV = 15;
  // {perr,uv,ov,tsd,tpw}[26:22] ol[21:16] oc[15:10] rd[9] status[8:1] gdis[0]
  localparam logic [26:0] VEC [NV] = '{
    {5'b00000, 6'h00, 6'h00, 1'b0, 8'h00, 1'b0},  // idle
    {5'b00001, 6'h00, 6'h00, 1'b0, 8'h02, 1'b0},  // R2 tpw pulse
    {5'b00000, 6'h00, 6'h00, 1'b0, 8'h02, 1'b0},  // R3 hold
    {5'b00000, 6'h00, 6'h00, 1'b1, 8'h08, 1'b0},  // R3 clear, R6 npor
    {5'b01000, 6'h00, 6'h00, 1'b0, 8'h28, 1'b1},  // R2 uv, R8
    {5'b01000, 6'h00, 6'h00, 1'b1, 8'h28, 1'b1},  // R4 persist
    {5'b00000, 6'h00, 6'h00, 1'b1, 8'h08, 1'b0},  // R3 R8 clear
    {5'b00000, 6'h04, 6'h00, 1'b0, 8'h48, 1'b0},  // R5 ol
    {5'b00000, 6'h04, 6'h00, 1'b1, 8'h48, 1'b0},  // R5 read no effect
    {5'b00000, 6'h00, 6'h00, 1'b0, 8'h08, 1'b0},  // R5 self clear
    {5'b10000, 6'h00, 6'h20, 1'b0, 8'hC8, 1'b0},  // R2 perr, R5 oc, R8 no gdis
    {5'b00110, 6'h00, 6'h00, 1'b0, 8'h9C, 1'b1},  // R2 ov tsd
    {5'b00000, 6'h00, 6'h00, 1'b1, 8'h08, 1'b0},  // R3 clear all
    {5'b00010, 6'h00, 6'h00, 1'b1, 8'h0C, 1'b1},  // R4 tsd during read
    {5'b00000, 6'h00, 6'h00, 1'b1, 8'h08, 1'b0}   // R3 R7
  };

  logic            clk = 1'b0;
  logic            rst_n;
  logic            rd_i, proto_err_i, uv_i, ov_i, tsd_i, tpw_i;
  logic [N_CH-1:0] ch_ol_i, ch_oc_i, ch_req_i;
  logic [7:0]      status_o;
  logic            gdis_o;
  logic [N_CH-1:0] ch_en_o;
  int              n_run = 0;
  int              n_fail = 0;
  bit              done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  drv_fault_status #(.N_CH(N_CH)) u_dut (
    .clk(clk), .rst_n(rst_n), .rd_i(rd_i), .proto_err_i(proto_err_i),
    .uv_i(uv_i), .ov_i(ov_i), .tsd_i(tsd_i), .tpw_i(tpw_i),
    .ch_ol_i(ch_ol_i), .ch_oc_i(ch_oc_i), .ch_req_i(ch_req_i),
    .status_o(status_o), .gdis_o(gdis_o), .ch_en_o(ch_en_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle_in();
    {proto_err_i, uv_i, ov_i, tsd_i, tpw_i} = '0;
    rd_i = 1'b0; ch_ol_i = '0; ch_oc_i = '0;
  endtask

  initial begin
    rst_n = 1'b0; ch_req_i = '1;
    idle_in();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check("R1 status", {24'h0, status_o}, 32'h00);
    check("R1 gdis", {31'h0, gdis_o}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      {proto_err_i, uv_i, ov_i, tsd_i, tpw_i} = VEC[i][26:22];
      ch_ol_i = VEC[i][21:16];
      ch_oc_i = VEC[i][15:10];
      rd_i    = VEC[i][9];
      @(negedge clk);
      // R2 R3 R4 R5 R6 R7 table row
      check($sformatf("R2-table row %0d status", i), {24'h0, status_o}, {24'h0, VEC[i][8:1]});
      check($sformatf("R8 row %0d gdis", i), {31'h0, gdis_o}, {31'h0, VEC[i][0]});
    end

    // R9 overcurrent on channel 1 gates only that channel
    idle_in();
    ch_oc_i = 6'b000010;
    #1;
    check("R9 oc gate", {26'h0, ch_en_o}, 32'h3D);
    @(negedge clk);
    // R8 undervoltage disables every channel
    ch_oc_i = '0; uv_i = 1'b1;
    @(negedge clk);
    check("R8 gdis on", {31'h0, gdis_o}, 32'h1);
    check("R9 all off", {26'h0, ch_en_o}, 32'h00);
    uv_i = 1'b0; rd_i = 1'b1;
    @(negedge clk);
    rd_i = 1'b0;
    check("R8 gdis off", {31'h0, gdis_o}, 32'h0);
    check("R9 all on", {26'h0, ch_en_o}, 32'h3F);
    check("R6 npor kept", {24'h0, status_o}, 32'h08);

    // R1 R6 asynchronous reset mid-run
    tpw_i = 1'b1;
    @(negedge clk);
    tpw_i = 1'b0;
    rst_n = 1'b0;
    #1;
    check("R1 async clear", {24'h0, status_o}, 32'h00);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R6 npor zero after reset", {31'h0, status_o[3]}, 32'h0);
    rd_i = 1'b1;
    @(negedge clk);
    rd_i = 1'b0;
    check("R6 npor after read", {24'h0, status_o}, 32'h08);
    check("R7 reserved", {31'h0, status_o[0]}, 32'h0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule